// File: doc/BRIEF.md
# Pulse-Echo Acquisition Sequencer

This block runs the timing of a transmit-and-listen instrument built around a 10-bit high-speed ADC. A trigger starts a sequence of shots. Each shot follows a fixed order: a positive drive pulse, then a negative drive pulse, then a quiet delay, then an acquisition window, then idle time until the repetition period runs out. During the acquisition window every sample-clock cycle produces one 16-bit word. The word holds the ADC sample and six live status bits. It is written through a plain synchronous SRAM write port at an address that counts up from zero.

All durations are given in sample-clock cycles, and the block takes a copy of them when a sequence starts. In single mode a trigger produces exactly one shot. In loop mode shots repeat until the programmed shot count is reached. The sequence also ends early if the memory fills up. A sticky completion flag tells the host that the captured data can be read out.

Top module: `pe_seq_top`

## Requirements
- R1: After reset, busy, done, both pulse outputs and the write enable are low, and the address is zero.
- R2: A trigger seen on a clock edge while idle starts a sequence. The positive pulse output is then high for the first P cycles after that edge, where P is the positive-pulse length.
- R3: The negative pulse output is high for the N cycles right after the positive pulse. The two pulse outputs are never high together.
- R4: After the negative pulse and a delay of D cycles, the write enable is high for exactly A consecutive cycles, where A is the acquisition length. It is never high while the block is idle.
- R5: The write word holds the ADC value in bits 9:0, the two general-purpose inputs in bits 11:10, the negative-pulse state in bit 12, the positive-pulse state in bit 13 and the two position-index inputs in bits 15:14.
- R6: The address returns to zero when a sequence is accepted and rises by one after every write.
- R7: Consecutive shots start exactly R cycles apart, counted from one positive pulse start to the next, where R is the repetition length.
- R8: In single mode one shot is taken. Busy then falls and done rises as the repetition period of that shot ends.
- R9: In loop mode the number of shots equals the programmed shot count, and a count of zero gives one shot.
- R10: A write at the highest address ends the sequence on that edge. Busy falls, done rises and the address holds.
- R11: A trigger that arrives while busy is ignored: the sequence, its address and its timing continue unchanged.
- R12: Configuration inputs are captured when a sequence is accepted. Changing them during the sequence has no effect on it.
- R13: Done stays high until the next accepted trigger, which clears it. Busy and done are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_i | input | 1 | Start request, already synchronous to clk |
| loop_mode_i | input | 1 | 1 = loop mode, 0 = single mode |
| cfg_pos_len_i | input | CNT_W | Positive pulse length in cycles |
| cfg_neg_len_i | input | CNT_W | Negative pulse length in cycles |
| cfg_dly_len_i | input | CNT_W | Delay before acquisition in cycles |
| cfg_acq_len_i | input | CNT_W | Acquisition window in cycles |
| cfg_rep_len_i | input | CNT_W | Repetition period in cycles |
| cfg_shots_i | input | SHOT_W | Shot count for loop mode |
| adc_data_i | input | 10 | ADC sample |
| idx_i | input | 2 | Position-index inputs |
| gpio_i | input | 2 | General-purpose inputs |
| pulse_pos_o | output | 1 | Positive drive pulse |
| pulse_neg_o | output | 1 | Negative drive pulse |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | Sequence complete (sticky) |
| mem_we_o | output | 1 | SRAM write enable |
| mem_addr_o | output | ADDR_W | SRAM word address |
| mem_wdata_o | output | 16 | SRAM write word |

## Verification
The assertions assume that the repetition length is at least the sum of the four phase lengths and is not zero, and that the trigger is already synchronous to the clock. Under those conditions the phases never overrun the period, and the address step and memory-full properties hold. The bench only programs legal period values. It changes inputs one nanosecond after a rising edge, and it uses a narrow address bus so that the memory-full stop can be reached in a short run.

// File: rtl/pe_seq_pkg.sv
// Package: shared constants and the phase type for the pulse-echo sequencer.
// Assumes a 16-bit storage word and a 10-bit ADC sample.
package pe_seq_pkg;
    localparam int ADC_W  = 10;
    localparam int WORD_W = 16;
    localparam int STAT_W = WORD_W - ADC_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_POS,
        PH_NEG,
        PH_DLY,
        PH_ACQ,
        PH_WAIT
    } phase_e;
endpackage

// File: rtl/pe_shot_timer.sv
// Shot timer: counts cycles within one shot and decodes the phase from
// cumulative boundaries that are captured at sequence start.
// Assumes rep_len >= pos+neg+dly+acq and rep_len >= 1.
module pe_shot_timer #(
    parameter int CNT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic                  run,
    input  logic [CNT_W-1:0]      pos_len,
    input  logic [CNT_W-1:0]      neg_len,
    input  logic [CNT_W-1:0]      dly_len,
    input  logic [CNT_W-1:0]      acq_len,
    input  logic [CNT_W-1:0]      rep_len,
    output pe_seq_pkg::phase_e    phase,
    output logic                  shot_end
);
    import pe_seq_pkg::*;

    localparam int SUM_W = CNT_W + 2;

    logic [SUM_W-1:0] b_pos, b_neg, b_dly, b_acq;
    logic [CNT_W-1:0] rep_last;
    logic [CNT_W-1:0] tcnt;
    logic [SUM_W-1:0] tcnt_x;

    assign tcnt_x   = {2'b00, tcnt};
    assign shot_end = run && (tcnt == rep_last);

    // Capture the phase boundaries at sequence start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_pos    <= '0;
            b_neg    <= '0;
            b_dly    <= '0;
            b_acq    <= '0;
            rep_last <= '0;
        end else if (load) begin
            b_pos    <= SUM_W'(pos_len);
            b_neg    <= SUM_W'(pos_len) + SUM_W'(neg_len);
            b_dly    <= SUM_W'(pos_len) + SUM_W'(neg_len) + SUM_W'(dly_len);
            b_acq    <= SUM_W'(pos_len) + SUM_W'(neg_len) + SUM_W'(dly_len)
                        + SUM_W'(acq_len);
            rep_last <= rep_len - 1'b1;
        end
    end

    // Count cycles within the shot and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || load) begin
            tcnt <= '0;
        end else if (run) begin
            tcnt <= shot_end ? '0 : tcnt + 1'b1;
        end
    end

    // Decode the current phase from the cycle count.
    always_comb begin
        if (!run)                phase = PH_IDLE;
        else if (tcnt_x < b_pos) phase = PH_POS;
        else if (tcnt_x < b_neg) phase = PH_NEG;
        else if (tcnt_x < b_dly) phase = PH_DLY;
        else if (tcnt_x < b_acq) phase = PH_ACQ;
        else                     phase = PH_WAIT;
    end
endmodule

// File: rtl/pe_shot_ctrl.sv
// Shot controller: accepts a trigger while idle, counts shots, and ends the
// sequence on the last shot or on a memory-full stop. Done is sticky.
// Assumes trig is synchronous; a shot count of zero acts as one.
module pe_shot_ctrl #(
    parameter int SHOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              loop_mode,
    input  logic [SHOT_W-1:0] shots,
    input  logic              shot_end,
    input  logic              full_stop,
    output logic              start,
    output logic              active,
    output logic              done
);
    logic              loop_l;
    logic [SHOT_W-1:0] shots_l;
    logic [SHOT_W-1:0] shot_cnt;
    logic [SHOT_W:0]   shot_nxt;
    logic              last_shot;

    assign start     = trig && !active;
    assign shot_nxt  = {1'b0, shot_cnt} + 1'b1;
    assign last_shot = !loop_l || (shot_nxt >= {1'b0, shots_l});

    // Run and completion state, with the mode and count captured at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active   <= 1'b0;
            done     <= 1'b0;
            loop_l   <= 1'b0;
            shots_l  <= '0;
            shot_cnt <= '0;
        end else if (start) begin
            active   <= 1'b1;
            done     <= 1'b0;
            loop_l   <= loop_mode;
            shots_l  <= shots;
            shot_cnt <= '0;
        end else if (active) begin
            if (full_stop || (shot_end && last_shot)) begin
                active <= 1'b0;
                done   <= 1'b1;
            end else if (shot_end) begin
                shot_cnt <= shot_nxt[SHOT_W-1:0];
            end
        end
    end
endmodule

// File: rtl/pe_addr_gen.sv
// Address generator: clears on sequence start, steps once per write and
// holds at the top address, which it reports to the controller.
module pe_addr_gen #(
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              we,
    output logic [ADDR_W-1:0] addr,
    output logic              at_top
);
    assign at_top = &addr;

    // Step the write address.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr <= '0;
        end else if (we && !at_top) begin
            addr <= addr + 1'b1;
        end
    end
endmodule

// File: rtl/pe_word_pack.sv
// Word packer: places the ADC sample in the low bits and the six status
// bits above it (gpio, negative, positive, index from low to high).
module pe_word_pack
    import pe_seq_pkg::*;
(
    input  logic [ADC_W-1:0]  adc,
    input  logic [1:0]        idx,
    input  logic              pos,
    input  logic              neg,
    input  logic [1:0]        gpio,
    output logic [WORD_W-1:0] word
);
    logic [STAT_W-1:0] stat;

    assign stat = {idx, pos, neg, gpio};
    assign word[ADC_W-1:0] = adc;

    // Map each status bit above the sample field.
    for (genvar i = 0; i < STAT_W; i++) begin : g_stat
        assign word[ADC_W+i] = stat[i];
    end
endmodule

// File: rtl/pe_seq_top.sv
// Pulse-echo acquisition sequencer top: joins the controller, the shot
// timer, the address generator and the word packer.
// Assumes rep_len covers all four phases, and trig_i is synchronous.
module pe_seq_top #(
    parameter int CNT_W  = 16,
    parameter int SHOT_W = 8,
    parameter int ADDR_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig_i,
    input  logic              loop_mode_i,
    input  logic [CNT_W-1:0]  cfg_pos_len_i,
    input  logic [CNT_W-1:0]  cfg_neg_len_i,
    input  logic [CNT_W-1:0]  cfg_dly_len_i,
    input  logic [CNT_W-1:0]  cfg_acq_len_i,
    input  logic [CNT_W-1:0]  cfg_rep_len_i,
    input  logic [SHOT_W-1:0] cfg_shots_i,
    input  logic [9:0]        adc_data_i,
    input  logic [1:0]        idx_i,
    input  logic [1:0]        gpio_i,
    output logic              pulse_pos_o,
    output logic              pulse_neg_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [15:0]       mem_wdata_o
);
    import pe_seq_pkg::*;

    logic   start, active, shot_end, at_top, full_stop;
    phase_e phase;

    assign pulse_pos_o = (phase == PH_POS);
    assign pulse_neg_o = (phase == PH_NEG);
    assign mem_we_o    = (phase == PH_ACQ);
    assign full_stop   = mem_we_o && at_top;
    assign busy_o      = active;

    pe_shot_ctrl #(.SHOT_W(SHOT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig_i),
        .loop_mode (loop_mode_i),
        .shots     (cfg_shots_i),
        .shot_end  (shot_end),
        .full_stop (full_stop),
        .start     (start),
        .active    (active),
        .done      (done_o)
    );

    pe_shot_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .run      (active),
        .pos_len  (cfg_pos_len_i),
        .neg_len  (cfg_neg_len_i),
        .dly_len  (cfg_dly_len_i),
        .acq_len  (cfg_acq_len_i),
        .rep_len  (cfg_rep_len_i),
        .phase    (phase),
        .shot_end (shot_end)
    );

    pe_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (start),
        .we     (mem_we_o),
        .addr   (mem_addr_o),
        .at_top (at_top)
    );

    pe_word_pack u_pack (
        .adc  (adc_data_i),
        .idx  (idx_i),
        .pos  (pulse_pos_o),
        .neg  (pulse_neg_o),
        .gpio (gpio_i),
        .word (mem_wdata_o)
    );
endmodule

// File: rtl/pe_seq_chk.sv
// Checker: temporal properties of the sequencer, attached to the top module
// by bind. Assumes a legal repetition length and a synchronous trigger.
module pe_seq_chk #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic              pos,
    input logic              neg,
    input logic              we,
    input logic [ADDR_W-1:0] addr
);
    // R3
    pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos && neg));

    // R4
    we_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> busy);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr != {ADDR_W{1'b1}})) |=> (addr == $past(addr) + 1'b1));

    // R10
    full_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr == {ADDR_W{1'b1}})) |=> (done && !busy && addr == {ADDR_W{1'b1}}));

    // R13
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));

    // R13
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done) |-> busy);
endmodule

bind pe_seq_top pe_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .busy  (busy_o),
    .done  (done_o),
    .pos   (pulse_pos_o),
    .neg   (pulse_neg_o),
    .we    (mem_we_o),
    .addr  (mem_addr_o)
);

// File: tb/pe_seq_top_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared with the design on every
// falling edge; inputs change 1 ns after the rising edge.
module pe_seq_top_bench;
    localparam int CNT_W = 16, SHOT_W = 8, ADDR_W = 6;
    localparam int MAXA = (1 << ADDR_W) - 1;

    logic clk = 1'b0, rst_n = 1'b0, trig = 1'b0, loop_mode = 1'b0;
    logic [CNT_W-1:0] c_pos = 3, c_neg = 2, c_dly = 4, c_acq = 6, c_rep = 20;
    logic [SHOT_W-1:0] c_shots = 1;
    logic [9:0] adc = 10'h0;
    logic [1:0] idx = 2'b0, gpio = 2'b0;
    logic pos, neg, busy, done, we;
    logic [ADDR_W-1:0] addr;
    logic [15:0] wdata;

    int n_chk = 0, n_bad = 0;
    bit armed = 0, finished = 0;

    // Reference model state.
    int m_act = 0, m_done = 0, m_t = 0, m_shot = 0, m_addr = 0;
    int l_p, l_n, l_d, l_a, l_r, l_s, l_loop;
    int cyc = 0, pos_rises = 0, last_rise = -1, rise_gap = -1;
    bit prev_pos = 0;

    always #2.5 clk = ~clk;

    pe_seq_top #(.CNT_W(CNT_W), .SHOT_W(SHOT_W), .ADDR_W(ADDR_W)) u_pe_seq_top (
        .clk(clk), .rst_n(rst_n), .trig_i(trig), .loop_mode_i(loop_mode),
        .cfg_pos_len_i(c_pos), .cfg_neg_len_i(c_neg), .cfg_dly_len_i(c_dly),
        .cfg_acq_len_i(c_acq), .cfg_rep_len_i(c_rep), .cfg_shots_i(c_shots),
        .adc_data_i(adc), .idx_i(idx), .gpio_i(gpio),
        .pulse_pos_o(pos), .pulse_neg_o(neg), .busy_o(busy), .done_o(done),
        .mem_we_o(we), .mem_addr_o(addr), .mem_wdata_o(wdata)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Reference model update on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_done = 0; m_t = 0; m_shot = 0; m_addr = 0;
        end else if (m_act == 0) begin
            if (trig) begin
                l_p = c_pos; l_n = c_neg; l_d = c_dly; l_a = c_acq; l_r = c_rep;
                l_s = c_shots; l_loop = loop_mode;
                m_act = 1; m_done = 0; m_t = 0; m_shot = 0; m_addr = 0;
            end
        end else begin
            bit w, stop;
            w = (m_t >= l_p + l_n + l_d) && (m_t < l_p + l_n + l_d + l_a);
            stop = 0;
            if (w) begin
                if (m_addr == MAXA) stop = 1;
                else m_addr++;
            end
            if (stop) begin
                m_act = 0; m_done = 1;
            end else if (m_t == l_r - 1) begin
                if (!l_loop || m_shot + 1 >= l_s) begin
                    m_act = 0; m_done = 1;
                end else begin
                    m_shot++; m_t = 0;
                end
            end else begin
                m_t++;
            end
        end
    end

    // Compare every output against the model on each falling edge.
    always @(negedge clk) begin
        bit e_pos, e_neg, e_we;
        cyc++;
        e_pos = m_act && (m_t < l_p);
        e_neg = m_act && (m_t >= l_p) && (m_t < l_p + l_n);
        e_we  = m_act && (m_t >= l_p + l_n + l_d) && (m_t < l_p + l_n + l_d + l_a);
        if (armed) begin
            check("R2 pulse_pos", pos, e_pos);
            check("R3 pulse_neg", neg, e_neg);
            check("R4 mem_we", we, e_we);
            check("R8 busy", busy, m_act);
            check("R13 done", done, m_done);
            check("R6 addr", addr, m_addr);
            if (e_we)
                check("R5 wdata", wdata, {idx, e_pos, e_neg, gpio, adc});
            if (pos && !prev_pos) begin
                pos_rises++;
                if (last_rise >= 0) rise_gap = cyc - last_rise;
                last_rise = cyc;
            end
        end
        prev_pos = pos;
    end

    // Live sample and status stimulus.
    initial begin
        forever begin
            @(posedge clk); #1;
            adc  <= adc * 10'd5 + 10'd37;
            idx  <= idx + 2'd1;
            gpio <= gpio ^ adc[3:2];
        end
    end

    task automatic pulse_trig();
        @(posedge clk); #1 trig = 1'b1;
        @(posedge clk); #1 trig = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    // Watchdog.
    initial begin
        #(5.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        armed = 1;
        // R1: reset state
        check("R1 busy", busy, 0); check("R1 done", done, 0);
        check("R1 addr", addr, 0); check("R1 we", we, 0);
        check("R1 pos", pos, 0);

        // R8: single shot
        loop_mode = 0; c_pos = 3; c_neg = 2; c_dly = 4; c_acq = 6; c_rep = 20;
        pulse_trig();
        wait_idle();
        check("R8 single addr", addr, 6);
        check("R8 single pos count", pos_rises, 1);
        repeat (5) @(negedge clk);
        check("R13 done held", done, 1);

        // R9/R7/R11/R12: loop of 3 shots, config changed and trigger mid-run
        pos_rises = 0; last_rise = -1;
        loop_mode = 1; c_shots = 3; c_pos = 2; c_neg = 3; c_dly = 1; c_acq = 5; c_rep = 25;
        pulse_trig();
        check("R13 done cleared", done, 0);
        repeat (10) @(posedge clk);
        #1 c_acq = 9; c_rep = 40; c_shots = 7; loop_mode = 0;
        pulse_trig();
        @(negedge clk);
        check("R11 busy kept", busy, 1);
        wait_idle();
        check("R9 shots", pos_rises, 3);
        check("R7 period", rise_gap, 25);
        check("R12 latched acq", addr, 15);

        // R9: zero shot count gives one shot
        pos_rises = 0; last_rise = -1;
        loop_mode = 1; c_shots = 0; c_acq = 4; c_rep = 14;
        pulse_trig();
        wait_idle();
        check("R9 zero count", pos_rises, 1);

        // R10: memory-full stop in loop mode
        pos_rises = 0;
        c_shots = 8; c_pos = 1; c_neg = 1; c_dly = 2; c_acq = 10; c_rep = 30;
        pulse_trig();
        wait_idle();
        check("R10 addr held", addr, MAXA);
        check("R10 done", done, 1);
        check("R10 shots cut", pos_rises, 7);

        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule